// File: doc/BRIEF.md
# Prefixed Bit-Group Execution Unit

This unit executes the second byte of the bit-prefixed instruction group of an 8-bit accumulator processor. The front end hands it the opcode byte that follows the prefix, the operand byte already fetched, the displacement byte, the current flag byte and a two-bit operand mode. The mode says whether the operand came from a register, from the memory byte addressed by HL, or from an indexed address with a signed displacement. The unit works out the result byte, the new flag byte, which write-backs to perform, the offset to add to the index base, and how many clock cycles the instruction takes.

The datapath is combinational and feeds a registered output stage run by a two-state machine. In state `ST_IDLE` the unit waits. A high `op_valid` at a clock edge loads the output stage and takes the transition `IDLE_TO_DONE` into `ST_DONE`, where `done` is high for that cycle. From `ST_DONE`, another `op_valid` takes `DONE_TO_DONE` and loads a new result, so operations can run back to back. Otherwise the transition `DONE_TO_IDLE` drops `done` and clears the write strobes. The result, flags, select, offset and cycle count keep their values until the next accepted operation.

Top module: `bitop_exec_unit`

## Requirements
- R1: `done` is high in the cycle after every clock edge at which `op_valid` is high, and low in every other cycle. After reset, `done`, `reg_we` and `mem_we` are all 0.
- R2: Mode 0 (register) and mode 3 (treated the same way) set `reg_we`=1 with `reg_sel` equal to opcode bits 2:0. They also give `mem_we`=0, `ea_offset`=0 and `cycles`=8.
- R3: Mode 1 (memory at HL) sets `mem_we`=1 and `reg_we`=0. It gives `ea_offset`=0 and `cycles`=15.
- R4: Mode 2 (indexed) sets `mem_we`=1 and `cycles`=23. `ea_offset` is the displacement sign-extended to 16 bits, so 0xFE gives 0xFFFE.
- R5: In mode 2 the result is also copied to the register named by opcode bits 2:0 (`reg_we`=1, `reg_sel`=bits 2:0), unless that field is 6, in which case `reg_we`=0.
- R6: Opcode bits 7:6 = 11 sets bit n of the operand, where n is opcode bits 5:3. The flag byte is returned unchanged.
- R7: Opcode bits 7:6 = 10 clears bit n of the operand, where n is opcode bits 5:3. The flag byte is returned unchanged.
- R8: Opcode bits 7:6 = 00 with bits 5:3 = 000 rotates left circularly, and with 001 rotates right circularly. Carry receives the bit shifted out.
- R9: Opcode bits 5:3 = 010 rotates left through carry and 011 rotates right through carry. The incoming carry is flag bit 0, and the bit shifted out becomes the new carry.
- R10: Opcode bits 5:3 = 100 shifts left inserting 0, and 101 shifts right keeping bit 7. Code 110 shifts left inserting 1, and 111 shifts right inserting 0. In every case carry receives the bit shifted out.
- R11: After a rotate or shift the flag byte is built as follows. Bit 7 (S) is result bit 7. Bit 6 (Z) is set when the result is zero. Bit 4 (H) is 0. Bit 2 (P) is set on even parity of the result. Bit 1 (N) is 0. Bit 0 is carry. Bits 5 and 3 are copied from the incoming flags.
- R12: Opcode bits 7:6 = 01 (the test group, which this unit does not execute) passes the operand through as the result and leaves the flags unchanged. It sets both `reg_we` and `mem_we` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation presented this cycle |
| op_code | input | 8 | Opcode byte following the prefix |
| op_mode | input | 2 | Operand mode: 0 register, 1 memory at HL, 2 indexed, 3 as register |
| op_data | input | 8 | Operand byte |
| op_disp | input | 8 | Signed displacement for indexed mode |
| flags_in | input | 8 | Current flag byte |
| done | output | 1 | Result valid pulse |
| res_data | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| reg_we | output | 1 | Register write-back strobe |
| reg_sel | output | 3 | Register select for write-back |
| mem_we | output | 1 | Memory write-back strobe |
| ea_offset | output | 16 | Offset added to the address base |
| cycles | output | 5 | Clock-cycle count of the instruction |

## Verification
The hardest case to reach is the indexed form that writes memory and also copies into a register. Here the strobes, the register select and the sign-extended offset must all agree in the same result cycle. The stimulus drives opcodes whose low field names B, A and the memory code 6 under mode 2. It pairs them with both a negative and a positive displacement, so that the copy strobe and the upper offset bits are seen in both states. Carry-through rotates are reached by preloading `flags_in` with carry set and clear, and back-to-back strobes exercise the `DONE_TO_DONE` transition.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        MODE_REG = 2'd0,
        MODE_HL  = 2'd1,
        MODE_IDX = 2'd2,
        MODE_ALT = 2'd3
    } opnd_mode_e;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } op_group_e;

    typedef enum logic [2:0] {
        SH_RLC = 3'd0,
        SH_RRC = 3'd1,
        SH_RL  = 3'd2,
        SH_RR  = 3'd3,
        SH_SLA = 3'd4,
        SH_SRA = 3'd5,
        SH_SLL = 3'd6,
        SH_SRL = 3'd7
    } shift_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } unit_state_e;

    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_P = 2;
    localparam int FLG_H = 4;
    localparam int FLG_Z = 6;
    localparam int FLG_S = 7;

    localparam logic [2:0] SEL_MEM = 3'd6;

    typedef struct packed {
        logic       reg_we;
        logic       mem_we;
        logic [2:0] reg_sel;
    } wb_ctl_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 8,
    parameter int CYC_W   = 5,
    parameter int CYC_REG = 8,
    parameter int CYC_HL  = 15,
    parameter int CYC_IDX = 23
) (
    input  logic [7:0]        code,
    input  opnd_mode_e        mode,
    input  logic [DISP_W-1:0] disp,
    output op_group_e         group,
    output shift_op_e         sh_op,
    output logic [2:0]        bit_num,
    output wb_ctl_t           wb,
    output logic [ADDR_W-1:0] ea,
    output logic [CYC_W-1:0]  cyc
);

    localparam int EXT_W = ADDR_W - DISP_W;
    localparam logic [CYC_W-1:0] CYC_REG_V = CYC_REG[CYC_W-1:0];
    localparam logic [CYC_W-1:0] CYC_HL_V  = CYC_HL[CYC_W-1:0];
    localparam logic [CYC_W-1:0] CYC_IDX_V = CYC_IDX[CYC_W-1:0];

    logic writes_back;

    always_comb begin
        group       = op_group_e'(code[7:6]);
        sh_op       = shift_op_e'(code[5:3]);
        bit_num     = code[5:3];
        writes_back = (group != GRP_TEST);
    end

    always_comb begin
        wb.reg_sel = code[2:0];
        wb.reg_we  = 1'b0;
        wb.mem_we  = 1'b0;
        ea         = '0;
        cyc        = CYC_REG_V;
        unique case (mode)
            MODE_REG, MODE_ALT: begin
                wb.reg_we = writes_back;
                cyc       = CYC_REG_V;
            end
            MODE_HL: begin
                wb.mem_we = writes_back;
                cyc       = CYC_HL_V;
            end
            MODE_IDX: begin
                wb.mem_we = writes_back;
                wb.reg_we = writes_back && (code[2:0] != SEL_MEM);
                ea        = {{EXT_W{disp[DISP_W-1]}}, disp};
                cyc       = CYC_IDX_V;
            end
        endcase
    end

endmodule

// File: rtl/bitop_shifter.sv
module bitop_shifter
    import bitop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  shift_op_e    op,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout
);

    logic msb;
    logic lsb;

    always_comb begin
        msb = a[W-1];
        lsb = a[0];
        unique case (op)
            SH_RLC: begin r = {a[W-2:0], msb};  cout = msb; end
            SH_RRC: begin r = {lsb, a[W-1:1]};  cout = lsb; end
            SH_RL:  begin r = {a[W-2:0], cin};  cout = msb; end
            SH_RR:  begin r = {cin, a[W-1:1]};  cout = lsb; end
            SH_SLA: begin r = {a[W-2:0], 1'b0}; cout = msb; end
            SH_SRA: begin r = {msb, a[W-1:1]};  cout = lsb; end
            SH_SLL: begin r = {a[W-2:0], 1'b1}; cout = msb; end
            SH_SRL: begin r = {1'b0, a[W-1:1]}; cout = lsb; end
        endcase
    end

endmodule

// File: rtl/bitop_bitmod.sv
module bitop_bitmod #(
    parameter int W   = 8,
    parameter int N_W = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [N_W-1:0] bit_num,
    input  logic           set_not_clr,
    output logic [W-1:0]   r
);

    logic [W-1:0] sel_mask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign sel_mask[i] = (bit_num == i[N_W-1:0]);
    end

    always_comb begin
        if (set_not_clr) r = a | sel_mask;
        else             r = a & ~sel_mask;
    end

endmodule

// File: rtl/bitop_flags.sv
module bitop_flags
    import bitop_pkg::*;
#(
    parameter int W = 8
) (
    input  op_group_e    group,
    input  logic [W-1:0] result,
    input  logic         carry,
    input  logic [7:0]   flags_in,
    output logic [7:0]   flags_out
);

    always_comb begin
        flags_out = flags_in;
        if (group == GRP_SHIFT) begin
            flags_out[FLG_S] = result[W-1];
            flags_out[FLG_Z] = (result == '0);
            flags_out[FLG_H] = 1'b0;
            flags_out[FLG_P] = ~^result;
            flags_out[FLG_N] = 1'b0;
            flags_out[FLG_C] = carry;
        end
    end

endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 16,
    parameter int CYC_W   = 5,
    parameter int CYC_REG = 8,
    parameter int CYC_HL  = 15,
    parameter int CYC_IDX = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] op_data,
    input  logic [7:0]        op_disp,
    input  logic [7:0]        flags_in,
    output logic              done,
    output logic [DATA_W-1:0] res_data,
    output logic [7:0]        flags_out,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] ea_offset,
    output logic [CYC_W-1:0]  cycles
);

    localparam logic [CYC_W-1:0] CYC_REG_V = CYC_REG[CYC_W-1:0];
    localparam logic [CYC_W-1:0] CYC_HL_V  = CYC_HL[CYC_W-1:0];
    localparam logic [CYC_W-1:0] CYC_IDX_V = CYC_IDX[CYC_W-1:0];

    op_group_e         grp;
    shift_op_e         sh_op;
    logic [2:0]        bit_num;
    wb_ctl_t           wb_nxt;
    logic [ADDR_W-1:0] ea_nxt;
    logic [CYC_W-1:0]  cyc_nxt;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [DATA_W-1:0] bm_res;
    logic [DATA_W-1:0] res_nxt;
    logic [7:0]        flg_nxt;
    unit_state_e       state_q;
    unit_state_e       state_d;

    bitop_decode #(
        .ADDR_W (ADDR_W),
        .DISP_W (8),
        .CYC_W  (CYC_W),
        .CYC_REG(CYC_REG),
        .CYC_HL (CYC_HL),
        .CYC_IDX(CYC_IDX)
    ) u_dec (
        .code   (op_code),
        .mode   (opnd_mode_e'(op_mode)),
        .disp   (op_disp),
        .group  (grp),
        .sh_op  (sh_op),
        .bit_num(bit_num),
        .wb     (wb_nxt),
        .ea     (ea_nxt),
        .cyc    (cyc_nxt)
    );

    bitop_shifter #(.W(DATA_W)) u_shf (
        .a   (op_data),
        .op  (sh_op),
        .cin (flags_in[FLG_C]),
        .r   (sh_res),
        .cout(sh_carry)
    );

    bitop_bitmod #(.W(DATA_W)) u_bit (
        .a          (op_data),
        .bit_num    (bit_num),
        .set_not_clr(grp == GRP_SET),
        .r          (bm_res)
    );

    always_comb begin
        unique case (grp)
            GRP_SHIFT:        res_nxt = sh_res;
            GRP_TEST:         res_nxt = op_data;
            GRP_CLR, GRP_SET: res_nxt = bm_res;
        endcase
    end

    bitop_flags #(.W(DATA_W)) u_flg (
        .group    (grp),
        .result   (sh_res),
        .carry    (sh_carry),
        .flags_in (flags_in),
        .flags_out(flg_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE_TO_DONE, DONE_TO_DONE, DONE_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_DONE;
            ST_DONE: state_d = op_valid ? ST_DONE : ST_IDLE;
        endcase
    end

    // output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            flags_out <= '0;
            reg_we    <= 1'b0;
            reg_sel   <= '0;
            mem_we    <= 1'b0;
            ea_offset <= '0;
            cycles    <= '0;
        end else if (op_valid) begin
            res_data  <= res_nxt;
            flags_out <= flg_nxt;
            reg_we    <= wb_nxt.reg_we;
            reg_sel   <= wb_nxt.reg_sel;
            mem_we    <= wb_nxt.mem_we;
            ea_offset <= ea_nxt;
            cycles    <= cyc_nxt;
        end else begin
            reg_we    <= 1'b0;
            mem_we    <= 1'b0;
        end
    end

    assign done = (state_q == ST_DONE);

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done); // R1
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done && !reg_we && !mem_we); // R1
    AST_REG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_mode == 2'd0) && (op_code[7:6] != 2'b01)
        |=> reg_we && !mem_we && (cycles == CYC_REG_V) && (ea_offset == '0)); // R2
    AST_HL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_mode == 2'd1) && (op_code[7:6] != 2'b01)
        |=> mem_we && !reg_we && (cycles == CYC_HL_V)); // R3
    AST_IDX_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_mode == 2'd2)
        |=> (ea_offset[7:0] == $past(op_disp)) && (cycles == CYC_IDX_V)); // R4
    AST_BITMOD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[7]
        |=> (flags_out == $past(flags_in))
            && ($countones(res_data ^ $past(op_data)) <= 1)); // R6
    AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code[7:6] == 2'b00)
        |=> !flags_out[FLG_H] && !flags_out[FLG_N]); // R11
    AST_TEST_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code[7:6] == 2'b01)
        |=> !reg_we && !mem_we && (res_data == $past(op_data))); // R12

endmodule

// File: tb/sim_bitop_exec_unit.sv
`timescale 1ns/1ps
module sim_bitop_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = '0;
    logic [1:0]  op_mode = '0;
    logic [7:0]  op_data = '0;
    logic [7:0]  op_disp = '0;
    logic [7:0]  flags_in = '0;
    logic        done;
    logic [7:0]  res_data;
    logic [7:0]  flags_out;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic        mem_we;
    logic [15:0] ea_offset;
    logic [4:0]  cycles;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bitop_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_mode(op_mode), .op_data(op_data), .op_disp(op_disp),
        .flags_in(flags_in), .done(done), .res_data(res_data),
        .flags_out(flags_out), .reg_we(reg_we), .reg_sel(reg_sel),
        .mem_we(mem_we), .ea_offset(ea_offset), .cycles(cycles)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one operation, return at the negedge where the result is visible
    task automatic issue(input logic [7:0] code, input logic [1:0] mode,
                         input logic [7:0] data, input logic [7:0] disp,
                         input logic [7:0] flg);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_mode = mode;
        op_data = data; op_disp = disp; flags_in = flg;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input int res, input int flg,
                              input int rwe, input int sel, input int mwe,
                              input int ea, input int cyc);
        chk("R1", "done", done, 1);
        chk(req, "result", res_data, res);
        chk(req, "flags", flags_out, flg);
        chk(req, "reg_we", reg_we, rwe);
        if (rwe == 1) chk(req, "reg_sel", reg_sel, sel);
        chk(req, "mem_we", mem_we, mwe);
        chk(req, "ea_offset", ea_offset, ea);
        chk(req, "cycles", cycles, cyc);
    endtask

    task automatic t_reset();
        chk("R1", "reset done", done, 0);
        chk("R1", "reset reg_we", reg_we, 0);
        chk("R1", "reset mem_we", mem_we, 0);
    endtask

    task automatic t_circular();
        issue(8'h00, 2'd0, 8'h84, 8'h00, 8'h00);
        expect_out("R8", 8'h09, 8'h05, 1, 0, 0, 0, 8);
        issue(8'h09, 2'd0, 8'h01, 8'h00, 8'h00);   // RRC C
        expect_out("R8", 8'h80, 8'h81, 1, 1, 0, 0, 8);
        @(negedge clk);
        chk("R1", "done idle", done, 0);
        chk("R1", "reg_we idle", reg_we, 0);
    endtask

    task automatic t_through_carry();
        issue(8'h10, 2'd0, 8'h80, 8'h00, 8'h01);
        expect_out("R9", 8'h01, 8'h01, 1, 0, 0, 0, 8);
        issue(8'h18, 2'd0, 8'h01, 8'h00, 8'h00);
        expect_out("R9", 8'h00, 8'h45, 1, 0, 0, 0, 8);
        issue(8'h18, 2'd0, 8'h02, 8'h00, 8'h01);
        expect_out("R9", 8'h81, 8'h84, 1, 0, 0, 0, 8);
    endtask

    task automatic t_shifts();
        issue(8'h20, 2'd0, 8'h48, 8'h00, 8'h00);
        expect_out("R10", 8'h90, 8'h84, 1, 0, 0, 0, 8);
        issue(8'h2F, 2'd0, 8'h81, 8'h00, 8'h00);
        expect_out("R10", 8'hC0, 8'h85, 1, 7, 0, 0, 8);
        issue(8'h30, 2'd0, 8'h00, 8'h00, 8'h00);
        expect_out("R10", 8'h01, 8'h00, 1, 0, 0, 0, 8);
        issue(8'h38, 2'd3, 8'h81, 8'h00, 8'h00);
        expect_out("R2", 8'h40, 8'h01, 1, 0, 0, 0, 8);
    endtask

    task automatic t_hl_mode();
        // SRA (HL) with flags_in all ones: bits 5 and 3 survive (R11)
        issue(8'h2E, 2'd1, 8'h10, 8'h00, 8'hFF);
        expect_out("R3", 8'h08, 8'h28, 0, 0, 1, 0, 15);
        chk("R11", "undef bits kept", flags_out & 8'h28, 8'h28);
    endtask

    task automatic t_indexed();
        issue(8'h00, 2'd2, 8'h08, 8'hFE, 8'h00);
        expect_out("R4", 8'h10, 8'h00, 1, 0, 1, 16'hFFFE, 23);
        issue(8'h0F, 2'd2, 8'h08, 8'h32, 8'h00);
        expect_out("R5", 8'h04, 8'h00, 1, 7, 1, 16'h0032, 23);
        issue(8'h06, 2'd2, 8'h84, 8'h80, 8'h00);
        expect_out("R5", 8'h09, 8'h05, 0, 0, 1, 16'hFF80, 23);
    endtask

    task automatic t_set_res();
        for (int n = 0; n < 8; n++) begin
            issue(8'hC6 | 8'(n << 3), 2'd1, 8'h55, 8'h00, 8'hA5);
            chk("R6", "set result", res_data, 8'h55 | 8'(1 << n));
            chk("R6", "set flags", flags_out, 8'hA5);
        end
        for (int n = 0; n < 8; n++) begin
            issue(8'h87 | 8'(n << 3), 2'd0, 8'hAA, 8'h00, 8'h3C);
            chk("R7", "res result", res_data, 8'hAA & ~8'(1 << n));
            chk("R7", "res flags", flags_out, 8'h3C);
            chk("R7", "res sel", reg_sel, 7);
        end
    endtask

    task automatic t_test_group();
        issue(8'h46, 2'd1, 8'h5A, 8'h00, 8'h11);
        expect_out("R12", 8'h5A, 8'h11, 0, 0, 0, 0, 15);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'h00; op_mode = 2'd0; op_data = 8'h01; flags_in = 8'h00;
        @(negedge clk);
        chk("R1", "b2b first", res_data, 8'h02);
        op_code = 8'h38; op_data = 8'h00;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R1", "b2b done", done, 1);
        chk("R11", "b2b zero flags", flags_out, 8'h44);
        @(negedge clk);
        chk("R1", "b2b drop", done, 0);
    endtask

    initial begin
        #4ms;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_circular();
        t_through_carry();
        t_shifts();
        t_hl_mode();
        t_indexed();
        t_set_res();
        t_test_group();
        t_back_to_back();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule